// File: doc/BRIEF.md
# Misaligned Word Access Trap Unit

This unit sits next to the load/store lanes of a multi-slot issue bundle. Each lane presents one word access per cycle. The access carries a valid bit, a load/store flag, a base-update flag, an effective address, store data and the PC of the instruction. An access is misaligned when either of its two low address bits is nonzero. Lane 0 is never checked, and its address goes to memory as issued. For every other lane the unit takes one of two actions. If the alignment mask input is high, it quietly rounds the address down to the word boundary. If the mask is low, it raises an exception request and records the fault.

Each checked lane owns one status record, which holds a status word, a fault-PC register and a fault-address register. Lane k uses record index `TRAP_BASE_IDX + k - 1`, so lanes 1 and 2 use indices 8 and 9. A summary vector shows one bit per record, at the bit position equal to the record index. When a trapped access is a store, its data is kept in a single exception data register. When a trapped access is a load, the unit kills the write to the load's destination register. A base-register update still goes ahead. A handler-return clear strobe, addressed by record index, drops the valid bit of that record.

Top module: `misalign_trap_unit`

## Requirements
- R1: With `mask_align` low, a valid access on lane 1 or 2 with `addr[1:0] != 0` drives `exc_req` high in that same cycle, and its `mem_addr` equals the issued address.
- R2: With `mask_align` high, no access raises `exc_req`, and a misaligned access on lane 1 or 2 gets `mem_addr` equal to its address with bits 1:0 cleared. No status record changes.
- R3: A lane-0 access, an aligned access and an invalid access each pass their address to `mem_addr` unchanged. None of them raises `exc_req` or changes any status record.
- R4: A trap on lane 1 fills record index 8 and a trap on lane 2 fills index 9. After the capturing edge, `exc_summary` bit 8 (0x100) or bit 9 (0x200) is set.
- R5: The status word uses this layout: bit 0 is valid, bits 5:1 are the cause (0x0B for misalignment), bit 11 is address-valid, bit 12 is data-valid and bits 16:13 are the data register number. A trapped load reads 0x0000_0817.
- R6: A trapped store sets data-valid and data register number 3, so the status word reads 0x0000_7817. `edr_q` then holds the store data. If both lanes trap a store in one cycle, the higher lane's data is kept.
- R7: On a trap, the record's PC output takes the access PC and its address output takes the full unmodified effective address.
- R8: `dest_wb_kill` for a lane is high in the same cycle as a trapped load on that lane. It is low for stores and for untrapped accesses.
- R9: `base_wb_en` for a lane equals valid AND base-update, whether or not the access traps.
- R10: When lanes 1 and 2 both trap in one cycle, both records are filled at the same edge.
- R11: A `clr_valid` strobe with `clr_idx` equal to a record index clears that record's valid bit and its summary bit. All other fields are kept. An index that matches no record has no effect. A capture in the same cycle on the same record wins over the clear.
- R12: After reset, every status word, PC, address, data and summary output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| mask_align | input | 1 | High: round misaligned addresses down instead of trapping |
| acc_valid | input | NUM_SLOTS | Per-lane access valid |
| acc_store | input | NUM_SLOTS | Per-lane store (1) / load (0) |
| acc_base_upd | input | NUM_SLOTS | Per-lane base-register update request |
| acc_addr | input | NUM_SLOTS x ADDR_W | Per-lane effective address |
| acc_wdata | input | NUM_SLOTS x DATA_W | Per-lane store data |
| acc_pc | input | NUM_SLOTS x PC_W | Per-lane instruction PC |
| clr_valid | input | 1 | Handler-return clear strobe |
| clr_idx | input | IDX_W | Record index targeted by the clear |
| mem_addr | output | NUM_SLOTS x ADDR_W | Address sent to memory |
| dest_wb_kill | output | NUM_SLOTS | Suppress the load destination write |
| base_wb_en | output | NUM_SLOTS | Allow the base-register update |
| exc_req | output | 1 | Exception request, high in the capture cycle |
| esr_q | output | (NUM_SLOTS-1) x 32 | Status word per checked lane |
| epc_q | output | (NUM_SLOTS-1) x PC_W | Faulting PC per checked lane |
| ear_q | output | (NUM_SLOTS-1) x ADDR_W | Faulting address per checked lane |
| edr_q | output | DATA_W | Exception data register (number 3) |
| exc_summary | output | 2**IDX_W | One bit per record index, set while that record is valid |

## Verification
The bench targets these corner cases:
- Masked and unmasked accesses on every lane at all three misaligned offsets. A design that ignores the mask or aligns lane 0 shows a wrong `mem_addr`.
- Both lanes faulting together. A design that serializes the faults leaves one record empty or keeps the lower lane's store data.
- A clear and a capture landing on the same record in one cycle, and a clear at a foreign index. Wrong priority loses a fault or wipes a record.
- Trapped loads with base update. Merging the destination kill with the base enable would drop the base write.

// File: rtl/misalign_pkg.sv
package misalign_pkg;
  localparam int ESR_W       = 32;
  localparam int F_VALID     = 0;
  localparam int F_CODE_LSB  = 1;
  localparam int F_CODE_W    = 5;
  localparam int F_ADDR_V    = 11;
  localparam int F_DATA_V    = 12;
  localparam int F_DREG_LSB  = 13;
  localparam int F_DREG_W    = 4;
  localparam logic [F_CODE_W-1:0] CODE_MISALIGN = 5'h0B;
  localparam logic [F_DREG_W-1:0] DREG_STORE    = 4'd3;

  function automatic logic [ESR_W-1:0] make_esr(input logic is_store);
    logic [ESR_W-1:0] w;
    w = '0;
    w[F_VALID] = 1'b1;
    w[F_CODE_LSB +: F_CODE_W] = CODE_MISALIGN;
    w[F_ADDR_V] = 1'b1;
    w[F_DATA_V] = is_store;
    w[F_DREG_LSB +: F_DREG_W] = is_store ? DREG_STORE : '0;
    return w;
  endfunction
endpackage

// File: rtl/misalign_lane_check.sv
module misalign_lane_check #(
  parameter int ADDR_W    = 32,
  parameter int WORD_LSBS = 2,
  parameter bit CHECKED   = 1'b1
) (
  input  logic              valid,
  input  logic              mask_align,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_out,
  output logic              trap
);
  logic off_word;
  assign off_word = |addr[WORD_LSBS-1:0];

  generate
    if (CHECKED) begin : g_checked
      always_comb begin
        trap     = valid && off_word && !mask_align;
        addr_out = addr;
        if (valid && off_word && mask_align)
          addr_out = {addr[ADDR_W-1:WORD_LSBS], {WORD_LSBS{1'b0}}};
      end
    end else begin : g_pass
      assign trap     = 1'b0;
      assign addr_out = addr;
    end
  endgenerate
endmodule

// File: rtl/misalign_status_rec.sv
module misalign_status_rec
  import misalign_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int MY_IDX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              cap_store,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [PC_W-1:0]   cap_pc,
  input  logic              clr_valid,
  input  logic [IDX_W-1:0]  clr_idx,
  output logic [ESR_W-1:0]  esr,
  output logic [PC_W-1:0]   epc,
  output logic [ADDR_W-1:0] ear
);
  localparam logic [IDX_W-1:0] SELF = IDX_W'(MY_IDX);

  logic [ESR_W-1:0] esr_d;
  logic             esr_en, fault_en, clr_hit;

  assign clr_hit  = clr_valid && (clr_idx == SELF);
  assign fault_en = cap;
  assign esr_en   = cap || clr_hit;

  always_comb begin
    esr_d = esr;
    if (cap)
      esr_d = make_esr(cap_store);
    else if (clr_hit)
      esr_d[F_VALID] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esr <= '0;
      epc <= '0;
      ear <= '0;
    end else begin
      if (esr_en)   esr <= esr_d;
      if (fault_en) epc <= cap_pc;
      if (fault_en) ear <= cap_addr;
    end
  end
endmodule

// File: rtl/misalign_trap_unit.sv
module misalign_trap_unit
  import misalign_pkg::*;
#(
  parameter int NUM_SLOTS     = 3,
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int PC_W          = 32,
  parameter int IDX_W         = 4,
  parameter int TRAP_BASE_IDX = 8,
  parameter int WORD_LSBS     = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 mask_align,
  input  logic [NUM_SLOTS-1:0]                 acc_valid,
  input  logic [NUM_SLOTS-1:0]                 acc_store,
  input  logic [NUM_SLOTS-1:0]                 acc_base_upd,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]     acc_addr,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0]     acc_wdata,
  input  logic [NUM_SLOTS-1:0][PC_W-1:0]       acc_pc,
  input  logic                                 clr_valid,
  input  logic [IDX_W-1:0]                     clr_idx,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]     mem_addr,
  output logic [NUM_SLOTS-1:0]                 dest_wb_kill,
  output logic [NUM_SLOTS-1:0]                 base_wb_en,
  output logic                                 exc_req,
  output logic [NUM_SLOTS-2:0][ESR_W-1:0]      esr_q,
  output logic [NUM_SLOTS-2:0][PC_W-1:0]       epc_q,
  output logic [NUM_SLOTS-2:0][ADDR_W-1:0]     ear_q,
  output logic [DATA_W-1:0]                    edr_q,
  output logic [(1<<IDX_W)-1:0]                exc_summary
);
  localparam int NUM_TRAP = NUM_SLOTS - 1;
  localparam int SUM_W    = 1 << IDX_W;

  logic [1:0]           rst_sync;
  logic                 rst_q_n;
  logic [NUM_SLOTS-1:0] lane_trap;
  logic [NUM_SLOTS-1:0] lane_cap;
  logic [DATA_W-1:0]    edr_d;
  logic                 edr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  genvar k;
  generate
    for (k = 0; k < NUM_SLOTS; k++) begin : g_lane
      misalign_lane_check #(
        .ADDR_W(ADDR_W), .WORD_LSBS(WORD_LSBS), .CHECKED(k != 0)
      ) u_chk (
        .valid(acc_valid[k]), .mask_align(mask_align), .addr(acc_addr[k]),
        .addr_out(mem_addr[k]), .trap(lane_trap[k])
      );
      assign lane_cap[k]     = lane_trap[k] && rst_q_n;
      assign dest_wb_kill[k] = lane_cap[k] && !acc_store[k];
      assign base_wb_en[k]   = acc_valid[k] && acc_base_upd[k];
    end
    for (k = 1; k < NUM_SLOTS; k++) begin : g_rec
      misalign_status_rec #(
        .ADDR_W(ADDR_W), .PC_W(PC_W), .IDX_W(IDX_W),
        .MY_IDX(TRAP_BASE_IDX + k - 1)
      ) u_rec (
        .clk(clk), .rst_n(rst_q_n),
        .cap(lane_cap[k]), .cap_store(acc_store[k]),
        .cap_addr(acc_addr[k]), .cap_pc(acc_pc[k]),
        .clr_valid(clr_valid), .clr_idx(clr_idx),
        .esr(esr_q[k-1]), .epc(epc_q[k-1]), .ear(ear_q[k-1])
      );
    end
  endgenerate

  assign exc_req = |lane_cap;

  always_comb begin
    edr_en = 1'b0;
    edr_d  = edr_q;
    for (int i = 1; i < NUM_SLOTS; i++) begin
      if (lane_cap[i] && acc_store[i]) begin
        edr_en = 1'b1;
        edr_d  = acc_wdata[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    edr_q <= '0;
    else if (edr_en) edr_q <= edr_d;
  end

  always_comb begin
    exc_summary = '0;
    for (int i = 0; i < NUM_TRAP; i++)
      exc_summary[TRAP_BASE_IDX + i] = esr_q[i][F_VALID];
  end

  logic unused_sum;
  assign unused_sum = ^SUM_W;
endmodule

// File: rtl/misalign_trap_chk.sv
module misalign_trap_chk
  import misalign_pkg::*;
#(
  parameter int NUM_SLOTS     = 3,
  parameter int ADDR_W        = 32,
  parameter int PC_W          = 32,
  parameter int IDX_W         = 4,
  parameter int TRAP_BASE_IDX = 8
) (
  input logic                             clk,
  input logic                             rst_q_n,
  input logic                             mask_align,
  input logic [NUM_SLOTS-1:0]             acc_valid,
  input logic [NUM_SLOTS-1:0]             acc_store,
  input logic [NUM_SLOTS-1:0]             acc_base_upd,
  input logic [NUM_SLOTS-1:0][ADDR_W-1:0] acc_addr,
  input logic [NUM_SLOTS-1:0][PC_W-1:0]   acc_pc,
  input logic                             clr_valid,
  input logic [IDX_W-1:0]                 clr_idx,
  input logic [NUM_SLOTS-1:0][ADDR_W-1:0] mem_addr,
  input logic [NUM_SLOTS-1:0]             dest_wb_kill,
  input logic [NUM_SLOTS-1:0]             base_wb_en,
  input logic                             exc_req,
  input logic [NUM_SLOTS-2:0][ESR_W-1:0]  esr_q,
  input logic [NUM_SLOTS-2:0][PC_W-1:0]   epc_q,
  input logic [NUM_SLOTS-2:0][ADDR_W-1:0] ear_q
);
  AST_MASK_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_q_n)
    mask_align |-> !exc_req); // R2

  AST_LANE0_PASS: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_addr[0] == acc_addr[0]); // R3

  genvar k;
  generate
    for (k = 1; k < NUM_SLOTS; k++) begin : g_ast
      AST_MASK_ALIGNS: assert property (@(posedge clk) disable iff (!rst_q_n)
        (mask_align && acc_valid[k]) |-> (mem_addr[k][1:0] == 2'b00)); // R2

      AST_TRAP_RAISES: assert property (@(posedge clk) disable iff (!rst_q_n)
        (!mask_align && acc_valid[k] && acc_addr[k][1:0] != 2'b00) |-> exc_req); // R1

      AST_TRAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_q_n)
        (!mask_align && acc_valid[k] && acc_addr[k][1:0] != 2'b00)
        |=> (esr_q[k-1][F_VALID] && ear_q[k-1] == $past(acc_addr[k])
             && epc_q[k-1] == $past(acc_pc[k]))); // R7

      AST_KILL_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_q_n)
        dest_wb_kill[k] |-> (!acc_store[k] && exc_req)); // R8

      AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_q_n)
        (clr_valid && clr_idx == IDX_W'(TRAP_BASE_IDX + k - 1)
         && !(acc_valid[k] && !mask_align && acc_addr[k][1:0] != 2'b00))
        |=> !esr_q[k-1][F_VALID]); // R11
    end
    for (k = 0; k < NUM_SLOTS; k++) begin : g_base
      AST_BASE_UPD: assert property (@(posedge clk) disable iff (!rst_q_n)
        (acc_valid[k] && acc_base_upd[k]) |-> base_wb_en[k]); // R9
    end
  endgenerate
endmodule

bind misalign_trap_unit misalign_trap_chk #(
  .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .PC_W(PC_W),
  .IDX_W(IDX_W), .TRAP_BASE_IDX(TRAP_BASE_IDX)
) u_trap_chk (
  .clk(clk), .rst_q_n(rst_q_n), .mask_align(mask_align),
  .acc_valid(acc_valid), .acc_store(acc_store), .acc_base_upd(acc_base_upd),
  .acc_addr(acc_addr), .acc_pc(acc_pc), .clr_valid(clr_valid), .clr_idx(clr_idx),
  .mem_addr(mem_addr), .dest_wb_kill(dest_wb_kill), .base_wb_en(base_wb_en),
  .exc_req(exc_req), .esr_q(esr_q), .epc_q(epc_q), .ear_q(ear_q)
);

// File: tb/misalign_trap_unit_tb.sv
`timescale 1ns/1ps
module misalign_trap_unit_tb;
  localparam int S  = 3;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic mask_align;
  logic [S-1:0] acc_valid, acc_store, acc_base_upd;
  logic [S-1:0][AW-1:0] acc_addr, acc_wdata, acc_pc;
  logic clr_valid;
  logic [3:0] clr_idx;
  logic [S-1:0][AW-1:0] mem_addr;
  logic [S-1:0] dest_wb_kill, base_wb_en;
  logic exc_req;
  logic [S-2:0][31:0] esr_q, epc_q, ear_q;
  logic [31:0] edr_q;
  logic [15:0] exc_summary;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  misalign_trap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mask_align(mask_align),
    .acc_valid(acc_valid), .acc_store(acc_store), .acc_base_upd(acc_base_upd),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_pc(acc_pc),
    .clr_valid(clr_valid), .clr_idx(clr_idx),
    .mem_addr(mem_addr), .dest_wb_kill(dest_wb_kill), .base_wb_en(base_wb_en),
    .exc_req(exc_req), .esr_q(esr_q), .epc_q(epc_q), .ear_q(ear_q),
    .edr_q(edr_q), .exc_summary(exc_summary)
  );

  localparam logic [31:0] ESR_LD = 32'h0000_0817;
  localparam logic [31:0] ESR_ST = 32'h0000_7817;

  typedef struct packed {
    logic [1:0] slot;
    logic       st;
    logic [1:0] low;
    logic       msk;
    logic       trap;
    logic [1:0] out_low;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd1, 1'b1, 2'd2, 1'b0, 1'b1, 2'd2},
    '{2'd1, 1'b1, 2'd2, 1'b1, 1'b0, 2'd0},
    '{2'd2, 1'b0, 2'd1, 1'b0, 1'b1, 2'd1},
    '{2'd2, 1'b0, 2'd3, 1'b1, 1'b0, 2'd0},
    '{2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0},
    '{2'd0, 1'b1, 2'd2, 1'b0, 1'b0, 2'd2},
    '{2'd0, 1'b0, 2'd3, 1'b1, 1'b0, 2'd3},
    '{2'd2, 1'b1, 2'd2, 1'b0, 1'b1, 2'd2}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    acc_valid = '0; acc_store = '0; acc_base_upd = '0;
    acc_addr = '0; acc_wdata = '0; acc_pc = '0;
    clr_valid = 1'b0; clr_idx = '0;
  endtask

  task automatic clear_rec(input logic [3:0] idx);
    @(negedge clk);
    clr_valid = 1'b1; clr_idx = idx;
    @(posedge clk); #1;
    clr_valid = 1'b0;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mask_align = 1'b0; idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    chk(esr_q == '0 && epc_q == '0 && ear_q == '0, "R12", esr_q[0], 32'h0);
    chk(edr_q == '0 && exc_summary == '0, "R12", {16'h0, exc_summary}, 32'h0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      logic [31:0] a, d, p;
      v = VEC[i];
      a = 32'h0000_1000 | 32'(v.low);
      d = 32'hA500_0000 + 32'(i);
      p = 32'h0000_0400 + 32'(i * 4);
      @(negedge clk);
      mask_align = v.msk;
      acc_valid[v.slot] = 1'b1; acc_store[v.slot] = v.st;
      acc_addr[v.slot] = a; acc_wdata[v.slot] = d; acc_pc[v.slot] = p;
      #1;
      chk(mem_addr[v.slot] == {a[31:2], v.out_low}, v.msk ? "R2" : (v.trap ? "R1" : "R3"),
          mem_addr[v.slot], {a[31:2], v.out_low});
      chk(exc_req == v.trap, v.trap ? "R1" : "R3", {31'h0, exc_req}, {31'h0, v.trap});
      chk(dest_wb_kill[v.slot] == (v.trap && !v.st), "R8",
          {31'h0, dest_wb_kill[v.slot]}, {31'h0, v.trap && !v.st});
      @(posedge clk); #1;
      idle(); mask_align = 1'b0;
      if (v.trap) begin
        chk(exc_summary == (16'h1 << (7 + v.slot)), "R4", {16'h0, exc_summary},
            {16'h0, 16'h1 << (7 + v.slot)});
        chk(esr_q[v.slot-1] == (v.st ? ESR_ST : ESR_LD), v.st ? "R6" : "R5",
            esr_q[v.slot-1], v.st ? ESR_ST : ESR_LD);
        chk(ear_q[v.slot-1] == a && epc_q[v.slot-1] == p, "R7", ear_q[v.slot-1], a);
        if (v.st) chk(edr_q == d, "R6", edr_q, d);
        clear_rec(4'(7 + v.slot));
        chk(exc_summary == '0, "R11", {16'h0, exc_summary}, 32'h0);
      end else begin
        chk(exc_summary == '0 && esr_q[0][0] == 1'b0 && esr_q[1][0] == 1'b0,
            v.msk ? "R2" : "R3", {16'h0, exc_summary}, 32'h0);
      end
    end

    // R11: cleared record keeps other fields (last vector was a slot-2 store)
    chk(esr_q[1] == (ESR_ST & ~32'h1), "R11", esr_q[1], ESR_ST & ~32'h1);

    // R10 + R6: both lanes trap stores in one cycle, lane 2 data wins
    @(negedge clk);
    acc_valid = 3'b110; acc_store = 3'b110;
    acc_addr[1] = 32'h2001; acc_addr[2] = 32'h3002;
    acc_wdata[1] = 32'h1111_1111; acc_wdata[2] = 32'h2222_2222;
    acc_pc[1] = 32'h500; acc_pc[2] = 32'h504;
    @(posedge clk); #1; idle();
    chk(exc_summary == 16'h0300, "R10", {16'h0, exc_summary}, 32'h0300);
    chk(ear_q[0] == 32'h2001 && ear_q[1] == 32'h3002, "R10", ear_q[0], 32'h2001);
    chk(edr_q == 32'h2222_2222, "R6", edr_q, 32'h2222_2222);

    // R11: foreign index no effect
    clear_rec(4'd5);
    chk(exc_summary == 16'h0300, "R11", {16'h0, exc_summary}, 32'h0300);
    clear_rec(4'd8);
    chk(exc_summary == 16'h0200, "R11", {16'h0, exc_summary}, 32'h0200);

    // R11: capture wins over same-cycle clear on index 9; R9 base update on trapped load
    @(negedge clk);
    acc_valid[2] = 1'b1; acc_store[2] = 1'b0; acc_base_upd[2] = 1'b1;
    acc_addr[2] = 32'h4003; acc_pc[2] = 32'h600;
    clr_valid = 1'b1; clr_idx = 4'd9;
    #1;
    chk(base_wb_en[2] == 1'b1 && dest_wb_kill[2] == 1'b1, "R9",
        {30'h0, base_wb_en[2], dest_wb_kill[2]}, 32'h3);
    @(posedge clk); #1; idle();
    chk(esr_q[1] == ESR_LD && epc_q[1] == 32'h600, "R11", esr_q[1], ESR_LD);
    chk(exc_summary == 16'h0200, "R11", {16'h0, exc_summary}, 32'h0200);

    // R9: base update on untrapped lane-0 access
    @(negedge clk);
    acc_valid[0] = 1'b1; acc_base_upd[0] = 1'b1; acc_addr[0] = 32'h7001;
    #1;
    chk(base_wb_en[0] == 1'b1 && exc_req == 1'b0, "R9", {31'h0, base_wb_en[0]}, 32'h1);
    @(posedge clk); #1; idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule